// File: doc/BRIEF.md
# Sixteen-bit up/down counter-timer

This block is one programmable 16-bit counter that counts up or down on either a qualifying pulse from an internal timebase or the rising edge of an external clock pin. Software loads a start value through a count-register write, and a control-register write picks the operating mode, the clock source, the gating source and the direction source. The live count can always be read back.

Two modes are defined. In event-count mode, OUT drops when a count is written and rises once the counter reaches zero, where it stays until the next count write. In pulse-generation mode, the counter reloads its start value every time it reaches zero, and OUT goes high for one counting period at each reload. Each terminal count sets a sticky interrupt request that software clears by writing a one.

Top module: `gp_updown_timer`

## Requirements
- R1: After reset the count, OUT, the interrupt request and all control fields are zero.
- R2: A count write loads the value into both the live count and the reload value, and drives OUT low on the next clock.
- R3: In event-count mode (control bits [1:0] = 00), OUT rises in the same clock in which the count becomes zero. If the count was already zero when it was loaded, OUT rises on the first counting step.
- R4: In event-count mode the counter does not wrap. Once at zero, further counting steps leave the count at zero and OUT high.
- R5: Each terminal count sets the interrupt request. A clear pulse drops it, but a terminal count in the same cycle takes priority and the request stays set.
- R6: Counting happens only when the enable bit (control bit 2) is set and the gate allows it. When gate select (bit 4) is 1 the synchronized gate pin must be high. When bit 4 is 0 the gate always allows counting.
- R7: The direction comes from bit 6 (1 = up) when direction select (bit 5) is 0, and from the synchronized direction pin (1 = up) when bit 5 is 1. Counting up from 0xFFFF reaches zero and counts as terminal count.
- R8: In pulse-generation mode (bits [1:0] = 01), a step that would reach zero instead reloads the start value and sets OUT high. The next step clears OUT again.
- R9: In the reserved modes (bits [1:0] = 10 or 11) the count does not change on counting steps.
- R10: With clock select (bit 3) at 0, each cycle in which the timebase tick input is high is a counting clock.
- R11: With clock select at 1, each rising edge of the external clock pin is one counting clock and the timebase tick is ignored. The count changes three clocks after the pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_int | input | 1 | Internal timebase qualifier, one counting clock per high cycle |
| cnt_wr | input | 1 | Count-register write strobe |
| cnt_wdata | input | 16 | Start value |
| ctl_wr | input | 1 | Control-register write strobe |
| ctl_wdata | input | 8 | Control value: [1:0] mode, [2] enable, [3] clock select, [4] gate select, [5] direction select, [6] direction when internal |
| irq_clr | input | 1 | Write-one clear of the interrupt request |
| ext_clk | input | 1 | External counting clock pin, asynchronous |
| ext_gate | input | 1 | External gate pin, asynchronous |
| ext_updn | input | 1 | External direction pin, asynchronous, 1 = up |
| count_q | output | 16 | Live count |
| out_q | output | 1 | Timer output |
| irq | output | 1 | Sticky terminal-count interrupt request |

## Verification
The hardest cases to reach are the ones driven by the external pins. A pin change only takes effect after the synchronizers, so the stimulus sets the gate, direction or clock pin, lets several idle cycles pass, and only then issues a counting step whose result is checked. Another hard case is an interrupt clear that lands in the same cycle as a terminal count. The stimulus reaches it by loading a start value of one in pulse mode and issuing the tick and the clear together. Up-count wrap is reached by loading 0xFFFE.

// File: rtl/gp_updown_timer.sv
module gp_updown_timer #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_int,
  input  logic          cnt_wr,
  input  logic [W-1:0]  cnt_wdata,
  input  logic          ctl_wr,
  input  logic [CW-1:0] ctl_wdata,
  input  logic          irq_clr,
  input  logic          ext_clk,
  input  logic          ext_gate,
  input  logic          ext_updn,
  output logic [W-1:0]  count_q,
  output logic          out_q,
  output logic          irq
);
  logic [CW-1:0] ctl_q;
  logic [W-1:0]  init_q;
  logic [2:0]    eclk_sh;
  logic [1:0]    gate_sh, dir_sh;

  wire mode_evt   = ctl_q[1:0] == 2'b00;
  wire mode_pulse = ctl_q[1:0] == 2'b01;
  wire clk_tick   = ctl_q[3] ? (eclk_sh[1] & ~eclk_sh[2]) : tick_int;
  wire gate_ok    = ctl_q[4] ? gate_sh[1] : 1'b1;
  wire count_up   = ctl_q[5] ? dir_sh[1] : ctl_q[6];
  wire step       = ctl_q[2] & gate_ok & clk_tick & ~cnt_wr;

  wire [W-1:0] nxt = count_up ? count_q + 1'b1 : count_q - 1'b1;
  wire at_zero  = count_q == '0;
  wire nxt_zero = nxt == '0;
  wire tc_hit   = step & ((mode_evt & ~out_q & (at_zero | nxt_zero)) |
                          (mode_pulse & nxt_zero));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      eclk_sh <= '0;
      gate_sh <= '0;
      dir_sh  <= '0;
    end else begin
      eclk_sh <= {eclk_sh[1:0], ext_clk};
      gate_sh <= {gate_sh[0], ext_gate};
      dir_sh  <= {dir_sh[0], ext_updn};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= ctl_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count_q <= '0;
      init_q  <= '0;
      out_q   <= 1'b0;
    end else if (cnt_wr) begin
      count_q <= cnt_wdata;
      init_q  <= cnt_wdata;
      out_q   <= 1'b0;
    end else if (step) begin
      if (mode_evt) begin
        if (!at_zero) count_q <= nxt;
        if (tc_hit)   out_q   <= 1'b1;
      end else if (mode_pulse) begin
        count_q <= nxt_zero ? init_q : nxt;
        out_q   <= nxt_zero;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       irq <= 1'b0;
    else if (tc_hit)  irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
endmodule

// File: rtl/gp_updown_timer_chk.sv
module gp_updown_timer_chk #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_wr,
  input logic [W-1:0]  cnt_wdata,
  input logic          irq_clr,
  input logic [CW-1:0] ctl_q,
  input logic [W-1:0]  count_q,
  input logic          out_q,
  input logic          irq
);
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (count_q == $past(cnt_wdata)) && !out_q);

  a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_clr));

  a_r3_out_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_q) && ctl_q[1:0] == 2'b00 && $past(ctl_q[1:0]) == 2'b00) |-> count_q == '0);

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[1:0] == 2'b00 && count_q == '0 && out_q && !cnt_wr) |=> count_q == '0 && out_q);

  a_r6_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[2] && !cnt_wr) |=> $stable(count_q));

  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[1] && !cnt_wr) |=> $stable(count_q));
endmodule

bind gp_updown_timer gp_updown_timer_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
  .irq_clr(irq_clr), .ctl_q(ctl_q), .count_q(count_q), .out_q(out_q), .irq(irq)
);

// File: tb/gp_updown_timer_test.sv
module gp_updown_timer_test;
  logic clk = 0, rst_n = 0;
  logic tick_int = 0, cnt_wr = 0, ctl_wr = 0, irq_clr = 0;
  logic ext_clk = 0, ext_gate = 0, ext_updn = 0;
  logic [15:0] cnt_wdata = 0;
  logic [7:0]  ctl_wdata = 0;
  logic [15:0] count_q;
  logic out_q, irq;

  typedef struct { string tag; logic [15:0] c; logic o; logic i; } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gp_updown_timer uut (.*);

  task automatic step(input bit t, input bit cw, input logic [15:0] cd,
                      input bit kw, input logic [7:0] kd, input bit clr);
    @(negedge clk);
    tick_int = t; cnt_wr = cw; cnt_wdata = cd; ctl_wr = kw; ctl_wdata = kd; irq_clr = clr;
    @(posedge clk); #1;
    tick_int = 0; cnt_wr = 0; ctl_wr = 0; irq_clr = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic tick(); step(1, 0, 0, 0, 0, 0); endtask
  task automatic load(input logic [15:0] v); step(0, 1, v, 0, 0, 0); endtask
  task automatic ctl(input logic [7:0] v); step(0, 0, 0, 1, v, 0); endtask
  task automatic clr(); step(0, 0, 0, 0, 0, 1); endtask

  task automatic expect_now(input string tag, input logic [15:0] c, input logic o, input logic i);
    exp_t e;
    e.tag = tag; e.c = c; e.o = o; e.i = i;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (count_q !== e.c || out_q !== e.o || irq !== e.i) begin
        errors++;
        $display("FAIL %s: got count=%h out=%b irq=%b, expected count=%h out=%b irq=%b",
                 e.tag, count_q, out_q, irq, e.c, e.o, e.i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_now("R1 reset", 16'h0, 0, 0);

    ctl(8'h04);
    load(16'd3);      expect_now("R2 load", 16'd3, 0, 0);
    tick();           expect_now("R10 tick", 16'd2, 0, 0);
    tick();           expect_now("R10 tick", 16'd1, 0, 0);
    tick();           expect_now("R3 terminal", 16'd0, 1, 1);
    tick();           expect_now("R4 stop at zero", 16'd0, 1, 1);
    clr();            expect_now("R5 clear", 16'd0, 1, 0);
    load(16'd0);      expect_now("R2 load zero", 16'd0, 0, 0);
    tick();           expect_now("R3 zero load", 16'd0, 1, 1);
    clr();            expect_now("R5 clear", 16'd0, 1, 0);

    ctl(8'h00);
    load(16'd5);      expect_now("R2 reload", 16'd5, 0, 0);
    tick();           expect_now("R6 disabled", 16'd5, 0, 0);
    ctl(8'h14);
    ext_gate = 0; idle(3);
    tick();           expect_now("R6 gate low", 16'd5, 0, 0);
    ext_gate = 1; idle(3);
    tick();           expect_now("R6 gate high", 16'd4, 0, 0);

    ctl(8'h44);
    load(16'hFFFE);
    tick();           expect_now("R7 up", 16'hFFFF, 0, 0);
    tick();           expect_now("R7 up wrap terminal", 16'h0000, 1, 1);
    clr();
    ctl(8'h24);
    ext_updn = 1; idle(3);
    load(16'd10);
    tick();           expect_now("R7 pin up", 16'd11, 0, 0);
    ext_updn = 0; idle(3);
    tick();           expect_now("R7 pin down", 16'd10, 0, 0);

    ctl(8'h05);
    load(16'd2);      expect_now("R8 load", 16'd2, 0, 0);
    tick();           expect_now("R8 count", 16'd1, 0, 0);
    tick();           expect_now("R8 reload pulse", 16'd2, 1, 1);
    tick();           expect_now("R8 pulse end", 16'd1, 0, 1);
    tick();           expect_now("R8 second pulse", 16'd2, 1, 1);

    ctl(8'h06);
    load(16'd7);
    tick();           expect_now("R9 reserved", 16'd7, 0, 1);
    ctl(8'h07);
    tick();           expect_now("R9 reserved 11", 16'd7, 0, 1);

    ctl(8'h05);
    clr();            expect_now("R5 clear", 16'd7, 0, 0);
    load(16'd1);
    step(1, 0, 0, 0, 0, 1); expect_now("R5 set beats clear", 16'd1, 1, 1);

    ctl(8'h0C);
    clr();
    load(16'd4);      expect_now("R11 load", 16'd4, 0, 0);
    tick();           expect_now("R11 tick ignored", 16'd4, 0, 0);
    ext_clk = 1; idle(2); expect_now("R11 sync delay", 16'd4, 0, 0);
    idle(1);          expect_now("R11 ext edge", 16'd3, 0, 0);
    ext_clk = 0; idle(4); expect_now("R11 falling ignored", 16'd3, 0, 0);
    ext_clk = 1; idle(4); expect_now("R11 second edge", 16'd2, 0, 0);

    idle(3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule